// File: doc/BRIEF.md
# Single-Cell Battery Protection State Controller

This block is the supervisory controller of a one-cell lithium battery protector. Analog comparators outside the block compare the cell voltage against several thresholds and compare the pack-negative sense node against current and charger thresholds. Each comparator delivers one digital flag. The controller qualifies these flags with internal hold timers and tracks which protection condition is active: normal, overcharged, overdischarged, overcurrent or powered down. From that it drives the charge-switch enable, the discharge-switch enable and a low-power request.

Several release rules depend on whether a charger is attached, which shows up as the sense node sitting below the charger-detect threshold. While a charger is present, an overcharge is held. An overdischarge is released at the lower, unhysteresised threshold. A sustained reverse sense voltage while discharge is allowed is treated as an abnormal charge current, and it drops the charge switch until it goes away. A configuration pin, captured only during reset, selects one of two behaviours for a nearly empty cell: charging is forced on, or charging is inhibited.

All qualification delays are counted in clock cycles and are set by parameters. Each output is a combinational function of the registered state, the reset-captured configuration and the near-empty flag.

Top module: `batt_guard_ctrl`

## Requirements
- R1: During and right after reset, with no comparator flag set, the block is in the normal state: chg_en=1, dis_en=1, pwr_dn=0.
- R2: In the normal state, if vbat_above_oc is high for OVC_DELAY consecutive sampling edges, chg_en goes to 0 after the last of those edges. A shorter run changes nothing.
- R3: In the overcharged state, the block returns to normal (chg_en=1) when vbat_below_ocrel=1 and sense_below_chg=0. While sense_below_chg=1 (charger attached) it stays overcharged even with vbat_below_ocrel=1.
- R4: In the overcharged state, a load (sense_above_ioc=1) together with vbat_above_oc=0 returns the block to normal. With vbat_above_oc=1 the load does not release it.
- R5: In the normal state, if vbat_below_od is high for ODC_DELAY consecutive edges, dis_en goes to 0 and chg_en stays 1. A shorter run changes nothing.
- R6: In the overdischarged state, sense_near_supply=1 enters power-down (pwr_dn=1, dis_en=0). In power-down, sense_near_supply=0 leaves power-down and goes back to the overdischarged state.
- R7: In the overdischarged state with sense_below_chg=1, the block returns to normal when vbat_below_od=0. With sense_below_chg=0, it returns only when vbat_above_odrel=1.
- R8: In the normal state, if sense_above_ioc is high for OCR_DELAY consecutive edges, dis_en goes to 0. It comes back on the edge after sense_above_ioc drops.
- R9: In the normal state, if sense_below_chg is high for OVC_DELAY consecutive edges, chg_en goes to 0 (abnormal charge current). dis_en stays 1. chg_en returns to 1 one edge after sense_below_chg drops.
- R10: With cfg_zero_chg=1 captured at reset, vbat_zero=1 forces chg_en=1 and stops abnormal-charge detection. With cfg_zero_chg=0 captured, vbat_zero=1 forces chg_en=0.
- R11: cfg_zero_chg is sampled only while rst_n=0. Changes to it outside reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; qualification delays are counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_zero_chg | input | 1 | Near-empty cell policy: 1 = force charging, 0 = inhibit; captured during reset |
| vbat_above_oc | input | 1 | Cell voltage above the overcharge threshold |
| vbat_below_ocrel | input | 1 | Cell voltage below the overcharge release threshold |
| vbat_below_od | input | 1 | Cell voltage below the overdischarge threshold |
| vbat_above_odrel | input | 1 | Cell voltage above the overdischarge threshold plus hysteresis |
| vbat_zero | input | 1 | Cell voltage near zero |
| sense_below_chg | input | 1 | Sense node below the charger-detect threshold (charger attached) |
| sense_above_ioc | input | 1 | Sense node above the overcurrent 1 threshold (load current) |
| sense_near_supply | input | 1 | Sense node within the power-down margin of the supply |
| chg_en | output | 1 | Charge switch enable |
| dis_en | output | 1 | Discharge switch enable |
| pwr_dn | output | 1 | Low-power request |

## Verification
The bound checker watches every cycle for two things. Any fall of the switch enables must trace back to a comparator flag sampled one edge earlier. Power-down may only be entered from a switched-off, near-supply condition, and left when the sense node moves away from the supply. The checker also confirms that the near-empty policy always overrides the charge enable, and that the captured configuration never moves outside reset. The bench's scenarios cover what a single-cycle property cannot: the exact number of edges each hold timer needs, including runs one edge too short; which release rule applies with and without a charger; and that the overcharge hold and the overcurrent priority work as sequences of states.

// File: rtl/bg_pkg.sv
// Shared definitions for the battery guard controller.
// Assumes: one clock domain, flags already synchronised.
package bg_pkg;

    // Protection states of the supervisor.
    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_OVCHG  = 3'd1,
        ST_OVDIS  = 3'd2,
        ST_OVCUR  = 3'd3,
        ST_PDOWN  = 3'd4
    } bg_state_e;

    // Index of each hold timer in the timer bank.
    localparam int unsigned TM_OVC = 0;   // overcharge qualification
    localparam int unsigned TM_ODC = 1;   // overdischarge qualification
    localparam int unsigned TM_OCR = 2;   // overcurrent qualification
    localparam int unsigned TM_ABN = 3;   // abnormal charge current qualification
    localparam int unsigned TM_NUM = 4;

    // Comparator flags bundled for internal routing.
    typedef struct packed {
        logic vbat_above_oc;
        logic vbat_below_ocrel;
        logic vbat_below_od;
        logic vbat_above_odrel;
        logic vbat_zero;
        logic sense_below_chg;
        logic sense_above_ioc;
        logic sense_near_supply;
    } bg_flags_t;

endpackage

// File: rtl/bg_hold_timer.sv
// Hold timer: raises expired when cond has been true, with en set,
// on DELAY consecutive sampling edges (the DELAY-th one included).
// Assumes: DELAY >= 1; the count restarts whenever cond or en drops.
module bg_hold_timer #(
    parameter int unsigned DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cond,
    output logic expired
);
    localparam int unsigned CW   = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt_q;

    // Count consecutive qualified cycles, saturating at the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!(en && cond)) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry is seen on the edge that completes the run.
    always_comb begin
        expired = en && cond && (cnt_q >= LAST);
    end

endmodule

// File: rtl/bg_fsm.sv
// Protection state machine: moves between normal, overcharge,
// overdischarge, overcurrent and power-down on qualified events,
// and tracks the abnormal-charge-current condition inside normal.
// Assumes: tm_exp comes from bg_hold_timer instances indexed per bg_pkg.
module bg_fsm
    import bg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bg_flags_t         flags,
    input  logic [TM_NUM-1:0] tm_exp,
    output bg_state_e         state,
    output logic              abn_flag
);
    bg_state_e state_d;
    logic      abn_d;
    logic      od_release;
    logic      oc_release;

    // Release conditions for the two voltage faults.
    always_comb begin
        // A charger lets overdischarge clear at the bare threshold.
        od_release = flags.sense_below_chg ? !flags.vbat_below_od
                                           : flags.vbat_above_odrel;
        // Overcharge clears by load, or by level once no charger is seen.
        oc_release = (flags.sense_above_ioc && !flags.vbat_above_oc) ||
                     (flags.vbat_below_ocrel && !flags.sense_below_chg);
    end

    // Next-state selection; overcurrent outranks overdischarge outranks overcharge.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_NORMAL: begin
                if (tm_exp[TM_OCR])      state_d = ST_OVCUR;
                else if (tm_exp[TM_ODC]) state_d = ST_OVDIS;
                else if (tm_exp[TM_OVC]) state_d = ST_OVCHG;
            end
            ST_OVCHG: begin
                if (oc_release) state_d = ST_NORMAL;
            end
            ST_OVDIS: begin
                if (od_release)                   state_d = ST_NORMAL;
                else if (flags.sense_near_supply) state_d = ST_PDOWN;
            end
            ST_OVCUR: begin
                if (!flags.sense_above_ioc) state_d = ST_NORMAL;
                else if (tm_exp[TM_ODC])    state_d = ST_OVDIS;
            end
            ST_PDOWN: begin
                if (!flags.sense_near_supply) state_d = ST_OVDIS;
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    // Abnormal-charge flag: lives only inside normal, clears with its cause.
    always_comb begin
        abn_d = abn_flag;
        if (state_d != ST_NORMAL) begin
            abn_d = 1'b0;
        end else if (abn_flag && !flags.sense_below_chg) begin
            abn_d = 1'b0;
        end else if (tm_exp[TM_ABN]) begin
            abn_d = 1'b1;
        end
    end

    // State and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_NORMAL;
            abn_flag <= 1'b0;
        end else begin
            state    <= state_d;
            abn_flag <= abn_d;
        end
    end

endmodule

// File: rtl/bg_switch_drive.sv
// Output decode: turns state, abnormal-charge flag and near-empty
// policy into switch enables and the power-down request.
// Assumes: zv_cfg is stable outside reset.
module bg_switch_drive
    import bg_pkg::*;
(
    input  bg_state_e state,
    input  logic      abn_flag,
    input  logic      zv_cfg,
    input  logic      vbat_zero,
    output logic      chg_en,
    output logic      dis_en,
    output logic      pwr_dn
);
    logic chg_base;

    // Per-state switch pattern before the near-empty policy.
    always_comb begin
        chg_base = 1'b1;
        dis_en   = 1'b1;
        pwr_dn   = 1'b0;
        unique case (state)
            ST_NORMAL: chg_base = !abn_flag;
            ST_OVCHG:  chg_base = 1'b0;
            ST_OVDIS:  dis_en   = 1'b0;
            ST_OVCUR:  dis_en   = 1'b0;
            ST_PDOWN: begin
                dis_en = 1'b0;
                pwr_dn = 1'b1;
            end
            default: begin
                chg_base = 1'b0;
                dis_en   = 1'b0;
            end
        endcase
    end

    // Near-empty cell: policy overrides the state pattern.
    always_comb begin
        if (vbat_zero) chg_en = zv_cfg;
        else           chg_en = chg_base;
    end

endmodule

// File: rtl/batt_guard_ctrl.sv
// Top of the battery guard controller: captures the near-empty policy
// in reset, qualifies comparator flags with a bank of hold timers,
// and runs the protection state machine and output decode.
// Assumes: comparator flags are synchronous to clk.
module batt_guard_ctrl
    import bg_pkg::*;
#(
    parameter int unsigned OVC_DELAY = 5,
    parameter int unsigned ODC_DELAY = 4,
    parameter int unsigned OCR_DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_zero_chg,
    input  logic vbat_above_oc,
    input  logic vbat_below_ocrel,
    input  logic vbat_below_od,
    input  logic vbat_above_odrel,
    input  logic vbat_zero,
    input  logic sense_below_chg,
    input  logic sense_above_ioc,
    input  logic sense_near_supply,
    output logic chg_en,
    output logic dis_en,
    output logic pwr_dn
);
    bg_flags_t         flags;
    bg_state_e         state;
    logic              abn_flag;
    logic              zv_cfg_q;
    logic [TM_NUM-1:0] tm_en;
    logic [TM_NUM-1:0] tm_cond;
    logic [TM_NUM-1:0] tm_exp;

    // Bundle the comparator flags.
    always_comb begin
        flags.vbat_above_oc     = vbat_above_oc;
        flags.vbat_below_ocrel  = vbat_below_ocrel;
        flags.vbat_below_od     = vbat_below_od;
        flags.vbat_above_odrel  = vbat_above_odrel;
        flags.vbat_zero         = vbat_zero;
        flags.sense_below_chg   = sense_below_chg;
        flags.sense_above_ioc   = sense_above_ioc;
        flags.sense_near_supply = sense_near_supply;
    end

    // Capture the near-empty policy only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) zv_cfg_q <= cfg_zero_chg;
    end

    // Timer conditions and the states in which each may count.
    always_comb begin
        tm_cond[TM_OVC] = vbat_above_oc;
        tm_en[TM_OVC]   = (state == ST_NORMAL);
        tm_cond[TM_ODC] = vbat_below_od;
        tm_en[TM_ODC]   = (state == ST_NORMAL) || (state == ST_OVCUR);
        tm_cond[TM_OCR] = sense_above_ioc;
        tm_en[TM_OCR]   = (state == ST_NORMAL);
        tm_cond[TM_ABN] = sense_below_chg;
        tm_en[TM_ABN]   = (state == ST_NORMAL) && !abn_flag &&
                          !(zv_cfg_q && vbat_zero);
    end

    // One hold timer per qualified event; abnormal charge shares the overcharge delay.
    for (genvar gi = 0; gi < TM_NUM; gi++) begin : g_tm
        localparam int unsigned DLY =
            (gi == TM_ODC) ? ODC_DELAY :
            (gi == TM_OCR) ? OCR_DELAY : OVC_DELAY;
        bg_hold_timer #(.DELAY(DLY)) u_tm (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (tm_en[gi]),
            .cond    (tm_cond[gi]),
            .expired (tm_exp[gi])
        );
    end

    bg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags    (flags),
        .tm_exp   (tm_exp),
        .state    (state),
        .abn_flag (abn_flag)
    );

    bg_switch_drive u_drv (
        .state     (state),
        .abn_flag  (abn_flag),
        .zv_cfg    (zv_cfg_q),
        .vbat_zero (vbat_zero),
        .chg_en    (chg_en),
        .dis_en    (dis_en),
        .pwr_dn    (pwr_dn)
    );

endmodule

// File: rtl/bg_checker.sv
// Cycle-by-cycle properties of the battery guard controller, bound to the top.
// Assumes: reset is held on the first clock edge.
module bg_checker (
    input logic clk,
    input logic rst_n,
    input logic chg_en,
    input logic dis_en,
    input logic pwr_dn,
    input logic vbat_above_oc,
    input logic vbat_below_od,
    input logic vbat_zero,
    input logic sense_below_chg,
    input logic sense_above_ioc,
    input logic sense_near_supply,
    input logic zv_cfg_q
);
    AST_DIS_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dis_en) |-> ($past(vbat_below_od) || $past(sense_above_ioc))); // R5 R8

    AST_CHG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(chg_en) && !vbat_zero && !$past(vbat_zero))
        |-> ($past(vbat_above_oc) || $past(sense_below_chg))); // R2 R9

    AST_PDN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_dn) |-> ($past(sense_near_supply) && !$past(dis_en))); // R6

    AST_PDN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_dn) |-> !$past(sense_near_supply)); // R6

    AST_ZV_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (zv_cfg_q && vbat_zero) |-> chg_en); // R10

    AST_ZV_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!zv_cfg_q && vbat_zero) |-> !chg_en); // R10

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(zv_cfg_q)); // R11

endmodule

bind batt_guard_ctrl bg_checker u_bg_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .chg_en            (chg_en),
    .dis_en            (dis_en),
    .pwr_dn            (pwr_dn),
    .vbat_above_oc     (vbat_above_oc),
    .vbat_below_od     (vbat_below_od),
    .vbat_zero         (vbat_zero),
    .sense_below_chg   (sense_below_chg),
    .sense_above_ioc   (sense_above_ioc),
    .sense_near_supply (sense_near_supply),
    .zv_cfg_q          (zv_cfg_q)
);

// File: tb/sim_batt_guard_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps run lengths around each hold delay and
// every charger/level combination of the release rules.
module sim_batt_guard_ctrl;
    localparam int unsigned OVC_D = 5;
    localparam int unsigned ODC_D = 4;
    localparam int unsigned OCR_D = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_zero_chg = 1'b1;
    logic vbat_above_oc = 1'b0, vbat_below_ocrel = 1'b1;
    logic vbat_below_od = 1'b0, vbat_above_odrel = 1'b1, vbat_zero = 1'b0;
    logic sense_below_chg = 1'b0, sense_above_ioc = 1'b0, sense_near_supply = 1'b0;
    logic chg_en, dis_en, pwr_dn;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    batt_guard_ctrl #(.OVC_DELAY(OVC_D), .ODC_DELAY(ODC_D), .OCR_DELAY(OCR_D)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_zero_chg(cfg_zero_chg),
        .vbat_above_oc(vbat_above_oc), .vbat_below_ocrel(vbat_below_ocrel),
        .vbat_below_od(vbat_below_od), .vbat_above_odrel(vbat_above_odrel),
        .vbat_zero(vbat_zero), .sense_below_chg(sense_below_chg),
        .sense_above_ioc(sense_above_ioc), .sense_near_supply(sense_near_supply),
        .chg_en(chg_en), .dis_en(dis_en), .pwr_dn(pwr_dn)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string rq, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", rq, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic cfg);
        rst_n = 1'b0;
        cfg_zero_chg = cfg;
        vbat_above_oc = 1'b0; vbat_below_ocrel = 1'b1;
        vbat_below_od = 1'b0; vbat_above_odrel = 1'b1; vbat_zero = 1'b0;
        sense_below_chg = 1'b0; sense_above_ioc = 1'b0; sense_near_supply = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic enter_ovchg();
        vbat_above_oc = 1'b1; vbat_below_ocrel = 1'b0;
        step(OVC_D);
        vbat_above_oc = 1'b0;
    endtask

    task automatic enter_ovdis();
        vbat_below_od = 1'b1; vbat_above_odrel = 1'b0;
        step(ODC_D);
    endtask

    task automatic leave_ovdis();
        sense_below_chg = 1'b0; sense_near_supply = 1'b0;
        vbat_below_od = 1'b0; vbat_above_odrel = 1'b1;
        step(1);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R1 reset state
        rst_n = 1'b0;
        step(1);
        chk(chg_en, 1'b1, "R1", "chg_en in reset");
        chk(dis_en, 1'b1, "R1", "dis_en in reset");
        chk(pwr_dn, 1'b0, "R1", "pwr_dn in reset");
        do_reset(1'b1);
        chk(chg_en, 1'b1, "R1", "chg_en after reset");
        chk(dis_en, 1'b1, "R1", "dis_en after reset");

        // R2 overcharge run-length sweep; R3 release by level
        for (int len = 1; len <= OVC_D + 2; len++) begin
            vbat_above_oc = 1'b1; vbat_below_ocrel = 1'b0;
            step(len);
            chk(chg_en, (len >= OVC_D) ? 1'b0 : 1'b1, "R2", $sformatf("chg_en after run %0d", len));
            vbat_above_oc = 1'b0; vbat_below_ocrel = 1'b1;
            step(1);
            chk(chg_en, 1'b1, "R3", "level release");
        end

        // R3 charger blocks release, removal releases
        enter_ovchg();
        vbat_below_ocrel = 1'b1; sense_below_chg = 1'b1;
        step(3);
        chk(chg_en, 1'b0, "R3", "held with charger");
        sense_below_chg = 1'b0;
        step(1);
        chk(chg_en, 1'b1, "R3", "release after charger removal");

        // R4 load release only below overcharge level
        enter_ovchg();
        vbat_above_oc = 1'b1; sense_above_ioc = 1'b1;
        step(1);
        chk(chg_en, 1'b0, "R4", "load above overcharge level");
        vbat_above_oc = 1'b0;
        step(1);
        chk(chg_en, 1'b1, "R4", "load release");
        chk(dis_en, 1'b1, "R4", "discharge on after load release");
        sense_above_ioc = 1'b0; vbat_below_ocrel = 1'b1;
        step(2);

        // R5 overdischarge run-length sweep
        for (int len = 1; len <= ODC_D + 2; len++) begin
            vbat_below_od = 1'b1; vbat_above_odrel = 1'b0;
            step(len);
            chk(dis_en, (len >= ODC_D) ? 1'b0 : 1'b1, "R5", $sformatf("dis_en after run %0d", len));
            chk(chg_en, 1'b1, "R5", "charge stays on");
            leave_ovdis();
            chk(dis_en, 1'b1, "R5", "recovered");
        end

        // R7 release rule over charger x level combinations
        for (int c = 0; c < 8; c++) begin
            logic chg_det, below_od, above_rel, exp_rel;
            chg_det = c[0]; below_od = c[1]; above_rel = c[2];
            if (below_od && above_rel) continue;
            enter_ovdis();
            sense_below_chg = chg_det; vbat_below_od = below_od; vbat_above_odrel = above_rel;
            step(1);
            exp_rel = chg_det ? !below_od : above_rel;
            chk(dis_en, exp_rel, "R7", $sformatf("charger=%0b below_od=%0b above_rel=%0b", chg_det, below_od, above_rel));
            leave_ovdis();
        end

        // R6 power-down entry and exit
        enter_ovdis();
        sense_near_supply = 1'b1;
        step(1);
        chk(pwr_dn, 1'b1, "R6", "enter power-down");
        chk(dis_en, 1'b0, "R6", "discharge off in power-down");
        step(2);
        chk(pwr_dn, 1'b1, "R6", "power-down held");
        sense_near_supply = 1'b0;
        step(1);
        chk(pwr_dn, 1'b0, "R6", "leave power-down");
        chk(dis_en, 1'b0, "R6", "still overdischarged");
        leave_ovdis();

        // R8 overcurrent run-length sweep and release
        for (int len = 1; len <= OCR_D + 2; len++) begin
            sense_above_ioc = 1'b1;
            step(len);
            chk(dis_en, (len >= OCR_D) ? 1'b0 : 1'b1, "R8", $sformatf("dis_en after run %0d", len));
            sense_above_ioc = 1'b0;
            step(1);
            chk(dis_en, 1'b1, "R8", "release");
        end

        // R9 abnormal charge current
        for (int len = OVC_D - 1; len <= OVC_D + 1; len++) begin
            sense_below_chg = 1'b1;
            step(len);
            chk(chg_en, (len >= OVC_D) ? 1'b0 : 1'b1, "R9", $sformatf("chg_en after run %0d", len));
            chk(dis_en, 1'b1, "R9", "discharge on");
            sense_below_chg = 1'b0;
            step(1);
            chk(chg_en, 1'b1, "R9", "clear");
        end

        // R10 forced charge outranks abnormal-charge detection
        vbat_zero = 1'b1; sense_below_chg = 1'b1;
        step(OVC_D + 3);
        chk(chg_en, 1'b1, "R10", "forced with reverse sense");
        vbat_zero = 1'b0;
        step(1);
        chk(chg_en, 1'b1, "R10", "no abnormal latch after force");
        sense_below_chg = 1'b0;
        step(1);

        // R10 inhibit policy; R11 capture only in reset
        do_reset(1'b0);
        vbat_zero = 1'b1;
        step(1);
        chk(chg_en, 1'b0, "R10", "inhibited near-empty");
        vbat_zero = 1'b0;
        cfg_zero_chg = 1'b1;
        step(3);
        vbat_zero = 1'b1;
        step(1);
        chk(chg_en, 1'b0, "R11", "policy unchanged after run-time pin change");
        vbat_zero = 1'b0;
        step(1);
        chk(chg_en, 1'b1, "R11", "normal charge after near-empty");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule